// File: doc/BRIEF.md
# Dual Programmable Ratio Divider

This block contains the two programmable counters that sit in front of a frequency synthesizer's phase comparator. One counter divides the reference clock by a 16-bit ratio R. The other divides the RF input clock by a 16-bit ratio N. Each counter emits a single-clock pulse once per ratio cycles of its own clock. Each pulse is driven onto two outputs: a buffered observation pin and the phase-comparator input. The two counters run in separate clock domains and share no state.

The ratios come from latches in a serial loader. Both ratio inputs are quasi-static, and each is driven in the domain of the counter it feeds. A ratio of zero switches its counter off. The counter then holds at its idle state, and its outputs stay low for as long as the ratio remains zero. A nonzero ratio below the legal minimum is raised to that minimum: 5 for the reference side and 1056 for the RF side. A change between two nonzero ratios is picked up only when the counter reloads at its terminal count, so a period never ends early or late because of the change. Neither side has a data stream, so both interfaces are plain level signals with no handshake.

Top module: `pll_ratio_dividers`

## Requirements
- R1: While its reset is asserted, and afterwards while its ratio is zero, a counter drives both of its outputs low.
- R2: With a reference ratio R in 5..65535, `ref_div_o` pulses exactly once every R rising edges of `ref_clk`.
- R3: With an RF ratio N in 1056..65535, `rf_div_o` pulses exactly once every N rising edges of `rf_clk`.
- R4: Every output pulse is high for exactly one clock of its own domain.
- R5: A nonzero reference ratio below 5 behaves exactly like a ratio of 5.
- R6: A nonzero RF ratio below 1056 behaves exactly like a ratio of 1056.
- R7: Driving a ratio to zero stops its counter on the next edge, and no pulse appears while the ratio stays zero.
- R8: On the first edge that samples a nonzero ratio after a disabled period, the counter loads that ratio. Its first pulse then appears after exactly that many further edges.
- R9: A change between two nonzero ratios during a period does not alter that period. The new ratio governs the period that begins at the next terminal count.
- R10: The two counters are independent: activity or ratio changes on one do not disturb the other's pulse spacing.
- R11: Each counter's two outputs, the pin and the phase-comparator input, carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference (crystal) clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| ref_ratio | input | 16 | Reference division ratio R; zero disables |
| rf_clk | input | 1 | RF input clock |
| rf_rst_n | input | 1 | Asynchronous active-low reset, RF domain |
| rf_ratio | input | 16 | RF division ratio N; zero disables |
| ref_div_o | output | 1 | Divided reference pulse, buffered pin |
| ref_pd_o | output | 1 | Divided reference pulse, phase-comparator input |
| rf_div_o | output | 1 | Divided RF pulse, buffered pin |
| rf_pd_o | output | 1 | Divided RF pulse, phase-comparator input |

## Verification
The bench targets several corner cases, each of which exposes a specific kind of defect:
- **Minimum legal ratios (5 and 1056).** A counter that loads the ratio instead of ratio minus one would drift by a full clock on every period.
- **Values just below each minimum (1055, 3, 1, 7).** A missing or wrong clamp would produce periods that are too short.
- **A ratio switched in mid-period.** A design that reloads immediately would shorten or stretch that period instead of finishing it at the old spacing.
- **Disable followed by re-enable.** A counter that keeps a stale count across the zero-ratio state would misplace its first pulse.

Both channels run concurrently on unrelated clocks, so any cross-coupling shows up as a spacing error on the other side.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned RATIO_W = 16;
  localparam int unsigned REF_MIN = 5;
  localparam int unsigned RF_MIN  = 1056;

  typedef logic [RATIO_W-1:0] ratio_t;

  // Raise a nonzero ratio to the channel minimum; zero passes through.
  function automatic logic [RATIO_W-1:0] floor_ratio(input logic [RATIO_W-1:0] r,
                                                      input int unsigned lo);
    if (r == '0)
      return '0;
    else if (32'(r) < lo)
      return RATIO_W'(lo);
    else
      return r;
  endfunction
endpackage

// File: rtl/ratio_clamp.sv
module ratio_clamp #(
  parameter int unsigned W   = 16,
  parameter int unsigned MIN = 5
) (
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] eff_o,
  output logic         off_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN);

  always_comb begin
    off_o = (ratio_i == '0);
    if (off_o)
      eff_o = '0;
    else if (ratio_i < MIN_V)
      eff_o = MIN_V;
    else
      eff_o = ratio_i;
  end

  // R5 / R6: a nonzero request never yields a ratio under the floor
  always_comb begin
    if (!$isunknown(ratio_i))
      a_r5_floor_held: assert (off_o || eff_o >= MIN_V);
  end
endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
  parameter int unsigned W   = 16,
  parameter int unsigned MIN = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  logic [W-1:0] eff;
  logic         off;
  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         pulse_q;

  ratio_clamp #(.W(W), .MIN(MIN)) i_clamp (
    .ratio_i (ratio_i),
    .eff_o   (eff),
    .off_o   (off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (off) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      cnt_q   <= eff - 1'b1;
      pulse_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q   <= eff - 1'b1;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  // R4: pulses are one clock wide
  a_r4_single_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // R7: a zero ratio idles the counter on the next edge
  a_r7_zero_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == '0) |=> (!pulse_q && !run_q && cnt_q == '0));

  // R9: mid-period the count only steps down, whatever the ratio input does
  a_r9_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && ratio_i != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9: the terminal count reloads from the ratio seen at that edge
  a_r9_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == '0 && ratio_i != '0) |=> (pulse_q && cnt_q == $past(eff) - 1'b1));

  // R8: leaving the idle state starts a full period with no pulse
  a_r8_clean_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && ratio_i != '0) |=> (run_q && !pulse_q && cnt_q == $past(eff) - 1'b1));
endmodule

// File: rtl/pll_ratio_dividers.sv
module pll_ratio_dividers
  import div_pkg::*;
#(
  parameter int unsigned W      = RATIO_W,
  parameter int unsigned R_LO   = REF_MIN,
  parameter int unsigned N_LO   = RF_MIN
) (
  input  logic         ref_clk,
  input  logic         ref_rst_n,
  input  logic [W-1:0] ref_ratio,
  input  logic         rf_clk,
  input  logic         rf_rst_n,
  input  logic [W-1:0] rf_ratio,
  output logic         ref_div_o,
  output logic         ref_pd_o,
  output logic         rf_div_o,
  output logic         rf_pd_o
);
  localparam int unsigned NCH = 2;

  logic         ch_clk   [NCH];
  logic         ch_rst_n [NCH];
  logic [W-1:0] ch_ratio [NCH];
  logic         ch_pulse [NCH];

  assign ch_clk[0]   = ref_clk;
  assign ch_rst_n[0] = ref_rst_n;
  assign ch_ratio[0] = ref_ratio;
  assign ch_clk[1]   = rf_clk;
  assign ch_rst_n[1] = rf_rst_n;
  assign ch_ratio[1] = rf_ratio;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned LO = (g == 0) ? R_LO : N_LO;
    prog_counter #(.W(W), .MIN(LO)) i_cnt (
      .clk_i   (ch_clk[g]),
      .rst_ni  (ch_rst_n[g]),
      .ratio_i (ch_ratio[g]),
      .pulse_o (ch_pulse[g])
    );
  end

  // R11: each pulse fans out to the pin and the comparator input
  assign ref_div_o = ch_pulse[0];
  assign ref_pd_o  = ch_pulse[0];
  assign rf_div_o  = ch_pulse[1];
  assign rf_pd_o   = ch_pulse[1];

  // R11: pin and comparator copies never disagree
  a_r11_ref_copies: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ref_div_o == ref_pd_o);
  a_r11_rf_copies: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    rf_div_o == rf_pd_o);
endmodule

// File: tb/test_pll_ratio_dividers.sv
module test_pll_ratio_dividers;
  logic        ref_clk = 1'b0;
  logic        rf_clk  = 1'b0;
  logic        ref_rst_n = 1'b0;
  logic        rf_rst_n  = 1'b0;
  logic [15:0] ref_ratio = '0;
  logic [15:0] rf_ratio  = '0;
  logic        ref_div_o, ref_pd_o, rf_div_o, rf_pd_o;

  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  always #5 ref_clk = ~ref_clk;   // 100 MHz
  always #3 rf_clk  = ~rf_clk;    // unrelated RF clock

  pll_ratio_dividers i_pll_ratio_dividers (
    .ref_clk, .ref_rst_n, .ref_ratio,
    .rf_clk, .rf_rst_n, .rf_ratio,
    .ref_div_o, .ref_pd_o, .rf_div_o, .rf_pd_o
  );

  function automatic int expect_ratio(input int ch, input int r);
    int lo;
    lo = (ch == 0) ? 5 : 1056;
    if (r == 0) return 0;
    return (r < lo) ? lo : r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int ch);
    if (ch == 0) @(negedge ref_clk); else @(negedge rf_clk);
  endtask

  function automatic logic pin(input int ch);
    return (ch == 0) ? ref_div_o : rf_div_o;
  endfunction

  function automatic logic pdin(input int ch);
    return (ch == 0) ? ref_pd_o : rf_pd_o;
  endfunction

  task automatic set_ratio(input int ch, input int v);
    if (ch == 0) ref_ratio = 16'(v); else rf_ratio = 16'(v);
  endtask

  // Count negedges until a pulse is seen (first edge counts as 1).
  task automatic wait_pulse(input int ch, output int n);
    n = 0;
    do begin
      tick(ch);
      n++;
    end while (!pin(ch) && n < 70000);
  endtask

  // Hold the ratio at zero for a while and confirm silence (R7, R1).
  task automatic go_idle(input int ch, input int cycles);
    int highs;
    highs = 0;
    set_ratio(ch, 0);
    for (int i = 0; i < cycles; i++) begin
      tick(ch);
      if (pin(ch) && i > 0) highs++;
    end
    chk(highs == 0, "R7 no pulse while ratio zero", highs, 0);
  endtask

  // Enable from idle, check first pulse and a few periods.
  task automatic run_ratio(input int ch, input int r, input int periods, input string tag);
    int exp, n;
    exp = expect_ratio(ch, r);
    go_idle(ch, 4);
    set_ratio(ch, r);
    wait_pulse(ch, n);
    chk(n == exp + 1, {"R8 first pulse ", tag}, n, exp + 1);
    chk(pdin(ch) == pin(ch), "R11 copies match", pdin(ch), pin(ch));
    for (int p = 0; p < periods; p++) begin
      tick(ch);
      chk(pin(ch) == 1'b0, "R4 pulse one clock wide", pin(ch), 0);
      wait_pulse(ch, n);
      chk(n == exp - 1, {"period ", tag}, n + 1, exp);
    end
  endtask

  // Change ratio mid-period: current period keeps the old spacing (R9).
  task automatic switch_mid(input int ch, input int a, input int b, input int k);
    int ea, eb, n;
    ea = expect_ratio(ch, a);
    eb = expect_ratio(ch, b);
    run_ratio(ch, a, 1, "R9 setup");
    for (int i = 0; i < k; i++) tick(ch);
    set_ratio(ch, b);
    wait_pulse(ch, n);
    chk(n + k == ea, "R9 old period completes", n + k, ea);
    tick(ch);
    wait_pulse(ch, n);
    chk(n + 1 == eb, "R9 new ratio next period", n + 1, eb);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1d5e);
    repeat (3) @(negedge ref_clk);
    chk(ref_div_o == 0 && ref_pd_o == 0, "R1 ref outputs low in reset", ref_div_o, 0);
    chk(rf_div_o == 0 && rf_pd_o == 0, "R1 rf outputs low in reset", rf_div_o, 0);
    @(negedge ref_clk); ref_rst_n = 1'b1;
    @(negedge rf_clk);  rf_rst_n  = 1'b1;
    repeat (5) @(negedge ref_clk);
    chk(ref_div_o == 0, "R1 ref low with zero ratio", ref_div_o, 0);
    chk(rf_div_o == 0, "R1 rf low with zero ratio", rf_div_o, 0);

    fork
      begin : ref_side
        run_ratio(0, 5, 3, "R2 minimum");
        run_ratio(0, 4, 2, "R5 clamp 4");
        run_ratio(0, 1, 2, "R5 clamp 1");
        run_ratio(0, 3, 2, "R5 clamp 3");
        run_ratio(0, 6, 2, "R2 six");
        run_ratio(0, 100, 2, "R2 hundred");
        for (int i = 0; i < 8; i++)
          run_ratio(0, 5 + int'($urandom_range(0, 400)), 3, "R2 random");
        switch_mid(0, 40, 17, 10);
        switch_mid(0, 12, 2, 3);
        switch_mid(0, 9, 60, 7);
      end
      begin : rf_side
        run_ratio(1, 1056, 3, "R3 R10 minimum");
        run_ratio(1, 1055, 2, "R6 clamp 1055");
        run_ratio(1, 7, 2, "R6 clamp 7");
        for (int i = 0; i < 5; i++)
          run_ratio(1, 1057 + int'($urandom_range(0, 1400)), 2, "R3 R10 random");
        switch_mid(1, 1200, 1100, 500);
        switch_mid(1, 1300, 20, 20);
      end
    join

    go_idle(0, 30);
    go_idle(1, 30);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge ref_clk);
    if (!done) begin
      applied++;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule